// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block sits behind the serial front end of a nonvolatile-style memory model and owns every change to the stored words. It keeps the program-enable latch, remembers the last fully framed command, and runs a self-timed cycle for a word erase, a word write, a whole-array erase or a whole-array write. The cycle starts when chip select is released after a complete command. From then on no serial clocks are needed. The timing comes from a down-counter on the system clock, and each program time is a separate parameter in clock ticks.

The front end gives a one-cycle `cmd_valid` strobe that carries the decoded operation, address and data, and a one-cycle `cs_fall` pulse when chip select drops. The sequencer shows `busy` for the whole cycle and commits results through a plain write port into a register-array memory. A whole-array write first fills the array with ones and then, after a second timed wait, writes the given word to every location. The write port has no handshake because the array takes one word on every clock. The command and status pins are level or pulse signals with no back-pressure.

Top module: `nvps_sequencer`

## Requirements
- R1: During reset and afterwards `busy` and `mem_we` are 0, and the enable latch is cleared. A reset asserted after an enable therefore blocks later programming commands.
- R2: `cmd_op` encoding: 0 read, 1 enable, 2 disable, 3 word erase, 4 array erase, 5 word write, 6 array write, 7 no operation. An accepted enable command sets the latch and an accepted disable command clears it.
- R3: A programming command (codes 3 to 6) framed while the latch is clear never raises `busy` and never pulses `mem_we`, even when `cs_fall` follows.
- R4: A cycle starts only on a `cs_fall` that arrives while a programming command is pending, the latch is set and `busy` is low. `busy` goes high on the following clock.
- R5: A word erase waits `T_WORD` cycles with `busy` high, then writes all ones to the latched address in a single `mem_we` cycle.
- R6: A word write has the same timing as R5 but writes the latched data word.
- R7: An array erase waits `T_ERAL` cycles, then writes all ones to every address, one address per clock in ascending order from 0.
- R8: An array write waits `T_ERAL` cycles and runs an ascending all-ones sweep. It then waits `T_WRAL` cycles and runs an ascending sweep of the latched data.
- R9: `busy` stays high from the start of the cycle through the last `mem_we` cycle and falls on the clock after it. `mem_we` is never high unless `busy` is high.
- R10: A `cmd_valid` or `cs_fall` that arrives while `busy` is high is ignored. It does not change the latch and does not leave a pending command.
- R11: Read and no-operation commands never start a cycle and do not affect the latch.
- R12: A `cs_fall` with no pending programming command does nothing. Any `cs_fall` taken while idle drops the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a command has been fully framed |
| cmd_op | input | 3 | Decoded operation, encoding as in R2 |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of the command |
| cs_fall | input | 1 | One-cycle pulse on the chip-select falling edge |
| busy | output | 1 | High while a program cycle runs |
| mem_we | output | 1 | Array write enable, one word per cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The checker assumes that `cmd_valid` and `cs_fall` are single-cycle pulses from a front end that never raises both on the same clock, and that the timing parameters are at least one. The stimulus drives each pulse for exactly one cycle from the falling clock edge and keeps the framing strobe and the chip-select pulse on separate clocks. When it deliberately sends traffic during a busy cycle, it sends each strobe and pulse on its own clock. With those limits, every rise of `busy` can be traced to a chip-select release, and the latch can change only while the sequencer is idle.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_EWEN  = 3'd1,
    OP_EWDS  = 3'd2,
    OP_ERASE = 3'd3,
    OP_ERAL  = 3'd4,
    OP_WRITE = 3'd5,
    OP_WRAL  = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WORD,
    ST_FILL
  } st_e;

  function automatic logic is_prog(input logic [2:0] op);
    return (op >= 3'd3) && (op <= 3'd6);
  endfunction

  function automatic logic is_word_op(input logic [2:0] op);
    return (op == 3'(OP_ERASE)) || (op == 3'(OP_WRITE));
  endfunction
endpackage

// File: rtl/nvps_wen_latch.sv
module nvps_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (set_en) en_q <= 1'b1;
    else if (clr_en) en_q <= 1'b0;
  end
endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nvps_addr_gen.sv
module nvps_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (step)  addr <= addr + 1'b1;
  end

  assign last = &addr;
endmodule

// File: rtl/nvps_sequencer.sv
module nvps_sequencer
  import nvps_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int unsigned T_WORD = 2000000,
  parameter int unsigned T_ERAL = 3000000,
  parameter int unsigned T_WRAL = 6000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs_fall,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned T_MAX1 = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
  localparam int unsigned T_MAX  = (T_MAX1 > T_WRAL) ? T_MAX1 : T_WRAL;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_WORD = CNT_W'(T_WORD - 1);
  localparam logic [CNT_W-1:0] LD_ERAL = CNT_W'(T_ERAL - 1);
  localparam logic [CNT_W-1:0] LD_WRAL = CNT_W'(T_WRAL - 1);

  st_e               state, state_nx;
  logic              accept, start;
  logic              wen_q;
  logic              pend_v;
  logic [2:0]        pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              erase_ph;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic              ag_clear, ag_step, ag_last;
  logic [ADDR_W-1:0] ag_addr;
  logic              wral_second;

  assign busy   = (state != ST_IDLE);
  assign accept = cmd_valid && !busy;
  assign start  = cs_fall && !busy && pend_v && wen_q;
  assign wral_second = (op_q == 3'(OP_WRAL)) && erase_ph;

  nvps_wen_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (accept && (cmd_op == 3'(OP_EWEN))),
    .clr_en (accept && (cmd_op == 3'(OP_EWDS))),
    .en_q   (wen_q)
  );

  nvps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  nvps_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ag_clear),
    .step  (ag_step),
    .addr  (ag_addr),
    .last  (ag_last)
  );

  // Pending command: replaced by any accepted framing, dropped by an idle chip-select release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_op   <= 3'(OP_NOP);
      pend_addr <= '0;
      pend_data <= '0;
    end else if (accept) begin
      pend_v    <= is_prog(cmd_op);
      pend_op   <= cmd_op;
      pend_addr <= cmd_addr;
      pend_data <= cmd_data;
    end else if (cs_fall && !busy) begin
      pend_v    <= 1'b0;
    end
  end

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ag_clear = 1'b0;
    ag_step  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_nx = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = is_word_op(pend_op) ? LD_WORD : LD_ERAL;
      end
      ST_WAIT: if (tmr_exp) begin
        state_nx = is_word_op(op_q) ? ST_WORD : ST_FILL;
        ag_clear = 1'b1;
      end
      ST_WORD: state_nx = ST_IDLE;
      ST_FILL: begin
        ag_step = 1'b1;
        if (ag_last) begin
          if (wral_second) begin
            state_nx = ST_WAIT;
            tmr_load = 1'b1;
            tmr_val  = LD_WRAL;
          end else begin
            state_nx = ST_IDLE;
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= 3'(OP_NOP);
      addr_q   <= '0;
      data_q   <= '0;
      erase_ph <= 1'b0;
    end else begin
      state <= state_nx;
      if (start) begin
        op_q     <= pend_op;
        addr_q   <= pend_addr;
        data_q   <= pend_data;
        erase_ph <= (pend_op != 3'(OP_WRITE));
      end else if (state == ST_FILL && ag_last && wral_second) begin
        erase_ph <= 1'b0;
      end
    end
  end

  assign mem_we    = (state == ST_WORD) || (state == ST_FILL);
  assign mem_addr  = (state == ST_FILL) ? ag_addr : addr_q;
  assign mem_wdata = erase_ph ? {DATA_W{1'b1}} : data_q;
endmodule

// File: rtl/nvps_checker.sv
module nvps_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wen_q,
  input logic [2:0]        op_q
);
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R9
  AST_BUSY_FALLS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we)); // R9
  AST_START_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall)); // R4
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q)); // R3
  AST_LATCH_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wen_q)); // R10
  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (op_q == 3'd3 || op_q == 3'd4)) |-> (&mem_wdata)); // R5
  AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && mem_addr != '0) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R7
endmodule

bind nvps_sequencer nvps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nvps_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_fall   (cs_fall),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wen_q     (wen_q),
  .op_q      (op_q)
);

// File: tb/test_nvps_sequencer.sv
`timescale 1ns/1ps
module test_nvps_sequencer;
  import nvps_pkg::*;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int TE = 6;
  localparam int TL = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd7;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          cs_fall = 1'b0;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  nvps_sequencer #(.ADDR_W(AW), .DATA_W(DW), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TL)) i_nvps_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cs_fall(cs_fall), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  typedef struct {
    bit            b;
    bit            we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit m_wen = 0, m_pend = 0, m_busy = 0;
  logic [2:0]    m_op = 3'd7;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push(input bit b, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.b = b; e.we = we; e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void push_cycle(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    string t;
    int wt;
    t = (op == 3'd3) ? "R5" : (op == 3'd5) ? "R6" : (op == 3'd4) ? "R7" : "R8";
    wt = (op == 3'd3 || op == 3'd5) ? TW : TE;
    for (int i = 0; i < wt; i++) push(1, 0, '0, '0, (i == 0) ? "R4" : "R9");
    if (op == 3'd3)      push(1, 1, a, '1, t);
    else if (op == 3'd5) push(1, 1, a, d, t);
    else begin
      for (int i = 0; i < DEPTH; i++) push(1, 1, AW'(i), '1, t);
      if (op == 3'd6) begin
        for (int i = 0; i < TL; i++) push(1, 0, '0, '0, "R9");
        for (int i = 0; i < DEPTH; i++) push(1, 1, AW'(i), d, t);
      end
    end
  endfunction

  // Reference model: decisions at the sampling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_wen = 0;
      m_pend = 0;
    end else begin
      if (cs_fall && !m_busy) begin
        if (m_pend && m_wen) push_cycle(m_op, m_addr, m_data);
        m_pend = 0;
      end
      if (cmd_valid && !m_busy) begin
        if (cmd_op == 3'd1) m_wen = 1;
        if (cmd_op == 3'd2) m_wen = 0;
        m_pend = (cmd_op >= 3'd3 && cmd_op <= 3'd6);
        m_op = cmd_op; m_addr = cmd_addr; m_data = cmd_data;
      end
    end
  end

  // Per-cycle comparison away from the sampling edge
  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      chk("R1", "busy in reset", 32'(busy), 0);
      chk("R1", "mem_we in reset", 32'(mem_we), 0);
      m_busy = 0;
    end else begin
      if (q.size() > 0) e = q.pop_front();
      else begin e.b = 0; e.we = 0; e.a = '0; e.d = '0; e.tag = cur_req; end
      chk(e.tag, "busy", 32'(busy), 32'(e.b));
      chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
      if (e.we && mem_we) begin
        chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.a));
        chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.d));
      end
      m_busy = e.b;
    end
  end

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_cs();
    @(negedge clk);
    cs_fall = 1;
    @(negedge clk);
    cs_fall = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #1; end while (q.size() != 0);
    idle(2);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    cur_req = "R3";                       // write with latch cleared after reset
    send(3'(OP_WRITE), 3'd2, 8'hA5); idle(2); pulse_cs(); idle(TW + 4);
    cur_req = "R12";                      // release with nothing pending
    pulse_cs(); idle(4);
    cur_req = "R2";
    send(3'(OP_EWEN), 3'd0, 8'h00); idle(2);
    cur_req = "R11";                      // read and no-op never start
    send(3'(OP_READ), 3'd1, 8'h00); pulse_cs(); idle(2);
    send(3'(OP_NOP), 3'd1, 8'h00); pulse_cs(); idle(TW + 4);
    cur_req = "R4";                       // no start until release
    send(3'(OP_WRITE), 3'd5, 8'h3C); idle(6); pulse_cs(); wait_done();
    cur_req = "R5";
    send(3'(OP_ERASE), 3'd5, 8'h00); pulse_cs(); wait_done();
    cur_req = "R7";
    send(3'(OP_ERAL), 3'd0, 8'h00); pulse_cs(); wait_done();
    cur_req = "R6";
    send(3'(OP_WRITE), 3'd0, 8'h00); pulse_cs(); wait_done();
    send(3'(OP_WRITE), 3'd7, 8'h81); pulse_cs(); wait_done();
    cur_req = "R10";                      // traffic while busy is dropped
    send(3'(OP_WRITE), 3'd2, 8'h11); pulse_cs(); idle(1);
    send(3'(OP_EWDS), 3'd0, 8'h00);
    send(3'(OP_WRITE), 3'd3, 8'h22); pulse_cs();
    wait_done();
    pulse_cs(); idle(TW + 3);
    send(3'(OP_WRITE), 3'd4, 8'h44); pulse_cs(); wait_done();
    cur_req = "R8";
    send(3'(OP_WRAL), 3'd0, 8'h5A); pulse_cs(); wait_done();
    cur_req = "R2";                       // disable blocks programming
    send(3'(OP_EWDS), 3'd0, 8'h00);
    send(3'(OP_ERASE), 3'd1, 8'h00); pulse_cs(); idle(TW + 4);
    cur_req = "R1";                       // reset clears the latch
    send(3'(OP_EWEN), 3'd0, 8'h00); idle(1);
    @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1);
    send(3'(OP_WRITE), 3'd6, 8'h77); pulse_cs(); idle(TW + 4);
    summary();
    $finish;
  end
endmodule